// File: doc/BRIEF.md
# Bidirectional Port with Bus Takeover

This block is one byte-wide general-purpose I/O port for a small microcontroller. Software reaches it through three decoded register offsets. Two of them hold state: a latched output value and a per-pin direction mask, and both can be read and written. The third is read-only and returns the pin levels after a two-stage synchronizer. Each pin's pad is modelled as four separate signals: an input, an output value, an output enable and a pull-up enable. When a pin is set as an input, its output-value bit also selects whether the pull-up is on.

An external-memory enable lets an external bus engine take over every pin, overriding the software direction and value. In the address phase the pins drive the address byte. In the write phase they drive the write data. In the read phase they are released, and the synchronized pin levels are returned as read data. Pull-ups are off for the whole time the takeover is active. Reset is asynchronous and active low. It clears both state registers, so all pins become floating inputs even when no clock is running.

Top module: `gpio_bidir_port`

## Requirements
- R1: A write to offset 0x18 updates the output latch. A read of 0x18 returns the latched value, whatever level the pins are at.
- R2: A write to offset 0x17 updates the direction mask (1 = drive). A read of 0x17 returns the mask.
- R3: Offset 0x16 is read-only. A write to it changes neither the latch nor the mask, and a read of it still returns the synchronized pin level.
- R4: A pin with direction 0 and latch bit 0 has output enable 0 and pull-up 0.
- R5: A pin with direction 0 and latch bit 1 has output enable 0 and pull-up 1.
- R6: A pin with direction 1 has output enable 1 and pull-up 0, and drives the latch bit on pad_out.
- R7: While rst_n is low, the latch and the mask read as zero and every pad_oe and pad_pu bit is 0. This takes effect with no clock edge.
- R8: A change on pad_in is visible through a read of 0x16 after the second rising clock edge, and not after the first.
- R9: With xbus_en = 1 and xbus_phase = 0 (address phase), all pins drive xbus_addr with pull-ups off, whatever the register contents.
- R10: With xbus_en = 1 and xbus_phase = 1 (write phase), all pins drive xbus_wdata with pull-ups off.
- R11: With xbus_en = 1 and xbus_phase = 2 (read) or 3 (idle), all pins are released with pull-ups off. xbus_rdata carries the synchronized pin level.
- R12: A read of any unmapped offset returns 0, and a write to one changes no register.
- R13: A register write becomes visible on bus_rdata only after the rising edge that samples bus_wr.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Port clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 6 | Register offset |
| bus_wr | input | 1 | Write strobe, sampled on the rising edge |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Combinational read data |
| pad_in | input | 8 | Pin levels from the pads |
| pad_out | output | 8 | Value driven onto the pins |
| pad_oe | output | 8 | Per-pin output enable |
| pad_pu | output | 8 | Per-pin pull-up enable |
| xbus_en | input | 1 | External bus takeover enable |
| xbus_phase | input | 2 | 0 address, 1 write, 2 read, 3 idle |
| xbus_addr | input | 8 | Address byte to drive |
| xbus_wdata | input | 8 | Write byte to drive |
| xbus_rdata | output | 8 | Synchronized pin level for bus reads |

## Verification
A wrong latch or mask bit shows up on pad_oe, pad_out and pad_pu in the same cycle as the register edge. It also shows up on a read of 0x18 or 0x17, so one register write followed by one read exposes it. A synchronizer that is too short or too long moves the visible change on a read of 0x16 by one edge, so the pin test samples after each of the two edges. A fault in the takeover multiplexer shows only while xbus_en is high, so every phase is held and checked against registers loaded with drive and pull-up patterns.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;
  localparam int unsigned ADDR_W   = 6;
  localparam logic [ADDR_W-1:0] OFS_PIN  = 6'h16;
  localparam logic [ADDR_W-1:0] OFS_DIR  = 6'h17;
  localparam logic [ADDR_W-1:0] OFS_DATA = 6'h18;

  typedef enum logic [1:0] {
    XB_ADDR  = 2'd0,
    XB_WDATA = 2'd1,
    XB_READ  = 2'd2,
    XB_IDLE  = 2'd3
  } xbus_phase_e;

  typedef enum logic [1:0] {
    SEL_NONE,
    SEL_DATA,
    SEL_DIR,
    SEL_PIN
  } reg_sel_e;

  function automatic reg_sel_e decode_sel(input logic [ADDR_W-1:0] a);
    case (a)
      OFS_DATA: return SEL_DATA;
      OFS_DIR:  return SEL_DIR;
      OFS_PIN:  return SEL_PIN;
      default:  return SEL_NONE;
    endcase
  endfunction

  // Pull-up is active only for an input pin whose latch bit is set.
  function automatic logic pull_on(input logic dir_b, input logic data_b);
    return data_b & ~dir_b;
  endfunction

  // In takeover mode only the address and write phases drive the pins.
  function automatic logic xbus_drives(input xbus_phase_e ph);
    return (ph == XB_ADDR) || (ph == XB_WDATA);
  endfunction
endpackage

// File: rtl/gpio_pin_sync.sv
module gpio_pin_sync #(
  parameter int unsigned WIDTH  = 8,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] pad_in,
  output logic [WIDTH-1:0] pin_sync
);
  logic [WIDTH-1:0] stg [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stg[0] <= '0;
    else        stg[0] <= pad_in;
  end

  for (genvar k = 1; k < STAGES; k++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stg[k] <= '0;
      else        stg[k] <= stg[k-1];
    end
  end

  assign pin_sync = stg[STAGES-1];

  if (STAGES == 2) begin : g_chk
    logic [1:0] seen;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         seen <= '0;
      else if (seen != 2) seen <= seen + 2'd1;
    end
    AST_SYNC_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
      (seen == 2'd2) |-> (pin_sync == $past(pad_in, 2))); // R8
  end
endmodule

// File: rtl/gpio_port_regs.sv
module gpio_port_regs
  import gpio_port_pkg::*;
#(
  parameter int unsigned WIDTH = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [WIDTH-1:0]  bus_wdata,
  input  logic [WIDTH-1:0]  pin_sync,
  output logic [WIDTH-1:0]  data_q,
  output logic [WIDTH-1:0]  dir_q,
  output logic [WIDTH-1:0]  bus_rdata
);
  reg_sel_e sel;
  logic     wr_data_ev;
  logic     wr_dir_ev;
  logic     wr_pin_ev;
  logic     wr_none_ev;

  assign sel        = decode_sel(bus_addr);
  assign wr_data_ev = bus_wr && (sel == SEL_DATA);
  assign wr_dir_ev  = bus_wr && (sel == SEL_DIR);
  assign wr_pin_ev  = bus_wr && (sel == SEL_PIN);
  assign wr_none_ev = bus_wr && (sel == SEL_NONE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0;
      dir_q  <= '0;
    end else begin
      if (wr_data_ev) data_q <= bus_wdata;
      if (wr_dir_ev)  dir_q  <= bus_wdata;
    end
  end

  always_comb begin
    case (sel)
      SEL_DATA: bus_rdata = data_q;
      SEL_DIR:  bus_rdata = dir_q;
      SEL_PIN:  bus_rdata = pin_sync;
      default:  bus_rdata = '0;
    endcase
  end

  AST_DATA_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_data_ev |=> (data_q == $past(bus_wdata))); // R1
  AST_DIR_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_dir_ev |=> (dir_q == $past(bus_wdata))); // R2
  AST_PIN_RO: assert property (@(posedge clk) disable iff (!rst_n)
    wr_pin_ev |=> ($stable(data_q) && $stable(dir_q))); // R3
  AST_UNMAPPED_WR: assert property (@(posedge clk) disable iff (!rst_n)
    wr_none_ev |=> ($stable(data_q) && $stable(dir_q))); // R12
endmodule

// File: rtl/gpio_pad_ctl.sv
module gpio_pad_ctl
  import gpio_port_pkg::*;
#(
  parameter int unsigned WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] data_q,
  input  logic [WIDTH-1:0] dir_q,
  input  logic             xbus_en,
  input  logic [1:0]       xbus_phase,
  input  logic [WIDTH-1:0] xbus_addr,
  input  logic [WIDTH-1:0] xbus_wdata,
  output logic [WIDTH-1:0] pad_out,
  output logic [WIDTH-1:0] pad_oe,
  output logic [WIDTH-1:0] pad_pu
);
  xbus_phase_e ph;
  logic        xb_drive;

  assign ph       = xbus_phase_e'(xbus_phase);
  assign xb_drive = xbus_drives(ph);

  for (genvar i = 0; i < WIDTH; i++) begin : g_pin
    always_comb begin
      if (xbus_en) begin
        pad_oe[i] = xb_drive;
        pad_pu[i] = 1'b0;
        case (ph)
          XB_ADDR:  pad_out[i] = xbus_addr[i];
          XB_WDATA: pad_out[i] = xbus_wdata[i];
          default:  pad_out[i] = 1'b0;
        endcase
      end else begin
        pad_oe[i]  = dir_q[i];
        pad_out[i] = data_q[i];
        pad_pu[i]  = pull_on(dir_q[i], data_q[i]);
      end
    end
  end

  AST_NO_PULL_WHILE_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
    (pad_oe & pad_pu) == '0); // R6
  AST_XBUS_NO_PULL: assert property (@(posedge clk) disable iff (!rst_n)
    xbus_en |-> (pad_pu == '0)); // R9
  AST_XBUS_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    (xbus_en && (ph == XB_READ || ph == XB_IDLE)) |-> (pad_oe == '0)); // R11
  AST_XBUS_WDATA: assert property (@(posedge clk) disable iff (!rst_n)
    (xbus_en && ph == XB_WDATA) |-> (pad_out == xbus_wdata && pad_oe == '1)); // R10
endmodule

// File: rtl/gpio_bidir_port.sv
module gpio_bidir_port
  import gpio_port_pkg::*;
#(
  parameter int unsigned WIDTH       = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [WIDTH-1:0]  bus_wdata,
  output logic [WIDTH-1:0]  bus_rdata,
  input  logic [WIDTH-1:0]  pad_in,
  output logic [WIDTH-1:0]  pad_out,
  output logic [WIDTH-1:0]  pad_oe,
  output logic [WIDTH-1:0]  pad_pu,
  input  logic              xbus_en,
  input  logic [1:0]        xbus_phase,
  input  logic [WIDTH-1:0]  xbus_addr,
  input  logic [WIDTH-1:0]  xbus_wdata,
  output logic [WIDTH-1:0]  xbus_rdata
);
  logic [WIDTH-1:0] pin_sync;
  logic [WIDTH-1:0] data_q;
  logic [WIDTH-1:0] dir_q;

  gpio_pin_sync #(.WIDTH(WIDTH), .STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .pad_in   (pad_in),
    .pin_sync (pin_sync)
  );

  gpio_port_regs #(.WIDTH(WIDTH)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_wr    (bus_wr),
    .bus_wdata (bus_wdata),
    .pin_sync  (pin_sync),
    .data_q    (data_q),
    .dir_q     (dir_q),
    .bus_rdata (bus_rdata)
  );

  gpio_pad_ctl #(.WIDTH(WIDTH)) u_pad (
    .clk        (clk),
    .rst_n      (rst_n),
    .data_q     (data_q),
    .dir_q      (dir_q),
    .xbus_en    (xbus_en),
    .xbus_phase (xbus_phase),
    .xbus_addr  (xbus_addr),
    .xbus_wdata (xbus_wdata),
    .pad_out    (pad_out),
    .pad_oe     (pad_oe),
    .pad_pu     (pad_pu)
  );

  assign xbus_rdata = pin_sync;

  AST_RESET_FLOAT: assert property (@(posedge clk)
    !rst_n |-> (pad_oe == '0 && pad_pu == '0)); // R7
endmodule

// File: tb/gpio_bidir_port_tb.sv
module gpio_bidir_port_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [5:0] bus_addr = '0;
  logic       bus_wr = 1'b0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic [7:0] pad_in = 8'h00;
  logic [7:0] pad_out, pad_oe, pad_pu;
  logic       xbus_en = 1'b0;
  logic [1:0] xbus_phase = 2'd3;
  logic [7:0] xbus_addr = '0;
  logic [7:0] xbus_wdata = '0;
  logic [7:0] xbus_rdata;

  int  n_checks = 0;
  int  n_fail = 0;
  bit  done = 0;

  always #4 clk = ~clk;

  gpio_bidir_port u_dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pad_in(pad_in),
    .pad_out(pad_out), .pad_oe(pad_oe), .pad_pu(pad_pu),
    .xbus_en(xbus_en), .xbus_phase(xbus_phase), .xbus_addr(xbus_addr),
    .xbus_wdata(xbus_wdata), .xbus_rdata(xbus_rdata)
  );

  // {dir, data, expected oe, expected out, expected pull-up}
  localparam logic [39:0] VEC [6] = '{
    40'h00_00_00_00_00,
    40'h00_FF_00_FF_FF,
    40'hFF_A5_FF_A5_00,
    40'hF0_3C_F0_3C_0C,
    40'h0F_96_0F_96_90,
    40'h55_FF_55_FF_AA
  };

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [5:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic read_chk(input string req, input logic [5:0] a, input logic [7:0] exp);
    bus_addr = a;
    #1;
    check(req, bus_rdata, exp);
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual running expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    // R7 reset state
    #20;
    check("R7 oe in reset", pad_oe, 8'h00);
    check("R7 pu in reset", pad_pu, 8'h00);
    read_chk("R7 latch in reset", 6'h18, 8'h00);
    read_chk("R7 mask in reset", 6'h17, 8'h00);
    @(negedge clk);
    rst_n = 1'b1;

    // R1 R2 R4 R5 R6 vector walk
    foreach (VEC[k]) begin
      bus_write(6'h17, VEC[k][39:32]);
      bus_write(6'h18, VEC[k][31:24]);
      #1;
      check("R4 R5 R6 pad_oe", pad_oe, VEC[k][23:16]);
      check("R6 pad_out", pad_out, VEC[k][15:8]);
      check("R4 R5 R6 pad_pu", pad_pu, VEC[k][7:0]);
      read_chk("R1 latch readback", 6'h18, VEC[k][31:24]);
      read_chk("R2 mask readback", 6'h17, VEC[k][39:32]);
    end

    // R13 write visible only after the edge
    @(negedge clk);
    bus_addr = 6'h18; bus_wdata = 8'h5A; bus_wr = 1'b1;
    #1;
    check("R13 before edge", bus_rdata, 8'hFF);
    @(negedge clk);
    bus_wr = 1'b0;
    #1;
    check("R13 after edge", bus_rdata, 8'h5A);

    // R1 latch read ignores pin level
    pad_in = 8'h0F;
    repeat (3) @(negedge clk);
    read_chk("R1 latch not pin", 6'h18, 8'h5A);

    // R3 pin register read-only
    bus_write(6'h16, 8'hE7);
    #1;
    read_chk("R3 latch kept", 6'h18, 8'h5A);
    read_chk("R3 mask kept", 6'h17, 8'h55);
    read_chk("R3 pin read", 6'h16, 8'h0F);

    // R12 unmapped offset
    bus_write(6'h20, 8'h3C);
    #1;
    read_chk("R12 unmapped read", 6'h20, 8'h00);
    read_chk("R12 latch kept", 6'h18, 8'h5A);
    read_chk("R12 mask kept", 6'h17, 8'h55);

    // R8 two-edge synchronizer
    @(negedge clk);
    pad_in = 8'hC3; bus_addr = 6'h16;
    @(negedge clk);
    #1;
    check("R8 after one edge", bus_rdata, 8'h0F);
    @(negedge clk);
    #1;
    check("R8 after two edges", bus_rdata, 8'hC3);

    // R9 R10 R11 bus takeover, registers hold drive and pull-up patterns
    bus_write(6'h17, 8'h0F);
    bus_write(6'h18, 8'hF0);
    @(negedge clk);
    xbus_en = 1'b1; xbus_phase = 2'd0; xbus_addr = 8'h12; xbus_wdata = 8'h34;
    #1;
    check("R9 addr oe", pad_oe, 8'hFF);
    check("R9 addr out", pad_out, 8'h12);
    check("R9 addr pu", pad_pu, 8'h00);
    @(negedge clk);
    xbus_phase = 2'd1;
    #1;
    check("R10 wdata oe", pad_oe, 8'hFF);
    check("R10 wdata out", pad_out, 8'h34);
    check("R10 wdata pu", pad_pu, 8'h00);
    @(negedge clk);
    xbus_phase = 2'd2; pad_in = 8'h6B;
    repeat (3) @(negedge clk);
    #1;
    check("R11 read oe", pad_oe, 8'h00);
    check("R11 read pu", pad_pu, 8'h00);
    check("R11 read data", xbus_rdata, 8'h6B);
    @(negedge clk);
    xbus_phase = 2'd3;
    #1;
    check("R11 idle oe", pad_oe, 8'h00);
    @(negedge clk);
    xbus_en = 1'b0;
    #1;
    check("R5 R6 control restored oe", pad_oe, 8'h0F);
    check("R5 control restored pu", pad_pu, 8'hF0);

    // R7 asynchronous reset between edges
    @(negedge clk);
    #2;
    rst_n = 1'b0;
    #1;
    check("R7 async oe", pad_oe, 8'h00);
    check("R7 async pu", pad_pu, 8'h00);
    read_chk("R7 async latch", 6'h18, 8'h00);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule